// File: doc/BRIEF.md
# Interrupt and Parallel Port Controller

This block gives a host processor one register-mapped point for collecting interrupt conditions and for general-purpose parallel I/O. A 7-bit input port is synchronised and filtered. The lowest four of its inputs also raise latched change-of-state flags. An 8-bit output port register drives the output pins inverted. Host writes to two separate command addresses set or clear single bits of this register.

Eight interrupt conditions are held in a status register. Seven of them come from external source inputs that are latched while high. The eighth reports that any change-of-state flag is pending. The status register is ANDed with a mask register, and any unmasked set bit asserts the pull-down enable of an active-low open-drain request line. The host uses a simple single-cycle strobe interface: a chip select plus separate read and write strobes, a 4-bit address and 8-bit data. Read data is registered.

Top module: `irq_pio_ctrl`

## Requirements
- R1: While reset is low and in the cycle after it, all eight `out_pins` are 1 and `irq_pull` is 0. After reset, reads of the status (address 2), mask (address 3) and output register (address 4) return 0.
- R2: `out_pins` is always the bitwise inverse of the output port register, which reads back at address 4.
- R3: A write to address 5 sets every output-register bit whose data bit is 1. The other bits keep their value.
- R4: A write to address 6 clears every output-register bit whose data bit is 1. The other bits keep their value.
- R5: Status bits 0 to 6 latch a high level on `irq_src[0..6]`. Writing a 1 to a bit of address 2 clears that bit, but a source that is high in the same cycle keeps the bit set. Bit 7 ignores such writes.
- R6: Status bit 7 is 1 exactly when at least one change-of-state flag is set.
- R7: `irq_pull` is 1 exactly when some status bit and the same mask bit (address 3, read/write) are both 1. Writing 0 to the mask releases it in the next cycle.
- R8: Address 0 reads {0, filtered levels of `in_pins[6:0]`}. A new input level is accepted only after two equal consecutive samples behind a two-flop synchroniser. It shows within five clock edges of the change. A one-cycle pulse is ignored.
- R9: Only `in_pins[3:0]` set change-of-state flags, when their accepted level changes. A read of address 1 returns {flags[3:0], levels[3:0]} and clears the flags in the same cycle.
- R10: Read data appears on `bus_rdata` in the cycle after the read strobe. Addresses 7 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Chip select for the host access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| in_pins | input | 7 | Asynchronous parallel inputs |
| irq_src | input | 7 | Interrupt source conditions, latched while high |
| out_pins | output | 8 | Parallel outputs, inverse of the output register |
| irq_pull | output | 1 | 1 enables the pull-down of the open-drain request line |

## Verification
A wrong output register or a wrong set/clear command shows on `out_pins` on the next clock edge. Every bus command is therefore checked at the pins one cycle after it is issued. A stuck or wrongly cleared status or mask bit shows on `irq_pull` at the same edge, and on the status read one cycle later. A fault in the input filter shows more slowly: an accepted level or a change flag first becomes visible about four edges after the pin moves. The bench therefore waits out that window before each read, and it also checks that a single-cycle glitch leaves both the levels and the flags unchanged.

// File: rtl/irq_pio_pkg.sv
// Shared register address map for the interrupt and parallel port controller.
// Assumes a 4-bit address bus; codes above the last entry are unmapped.
package irq_pio_pkg;
    localparam int unsigned ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        RA_INLVL  = 4'd0,
        RA_CHG    = 4'd1,
        RA_STAT   = 4'd2,
        RA_MASK   = 4'd3,
        RA_OUTREG = 4'd4,
        RA_OSET   = 4'd5,
        RA_OCLR   = 4'd6
    } reg_addr_e;
endpackage

// File: rtl/pio_in_filter.sv
// Input filter: two-flop synchroniser, then a stability stage that accepts a
// new level only when two consecutive synchronised samples agree. The lowest
// CHG_W inputs raise sticky change flags, cleared by chg_clr_i (set wins).
// Assumes pins are asynchronous and change no faster than the filter window.
module pio_in_filter #(
    parameter int unsigned IN_W  = 7,
    parameter int unsigned CHG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IN_W-1:0]  pins_i,
    input  logic             chg_clr_i,
    output logic [IN_W-1:0]  level_o,
    output logic [CHG_W-1:0] chg_o
);
    logic [IN_W-1:0]  sync1, sync2, sample_d, level_q, accept;
    logic [CHG_W-1:0] chg_q;

    // Bits whose last two samples agree and differ from the accepted level.
    assign accept = ~(sync2 ^ sample_d) & (sync2 ^ level_q);

    // Synchronise, keep one older sample, and update the accepted level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1    <= '0;
            sync2    <= '0;
            sample_d <= '0;
            level_q  <= '0;
        end else begin
            sync1    <= pins_i;
            sync2    <= sync1;
            sample_d <= sync2;
            level_q  <= level_q ^ accept;
        end
    end

    // Latch change flags on the watched inputs; a clear loses to a new change.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chg_q <= '0;
        else
            chg_q <= (chg_q & ~{CHG_W{chg_clr_i}}) | accept[CHG_W-1:0];
    end

    assign level_o = level_q;
    assign chg_o   = chg_q;
endmodule

// File: rtl/pio_out_reg.sv
// Output port register with bitwise set and clear commands.
// Assumes set_i and clr_i are never asserted together; set has priority.
module pio_out_reg #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_i,
    input  logic          clr_i,
    input  logic [DW-1:0] data_i,
    output logic [DW-1:0] q_o
);
    logic [DW-1:0] q;

    // Apply the set or clear command to the selected bits only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (set_i)
            q <= q | data_i;
        else if (clr_i)
            q <= q & ~data_i;
    end

    assign q_o = q;
endmodule

// File: rtl/irq_collect.sv
// Interrupt status and mask. The low SRC_W-1 status bits latch external
// sources and clear on write-one; the top bit mirrors a pending change flag.
// The request is the OR of masked status. Assumes sources are synchronous.
module irq_collect #(
    parameter int unsigned SRC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-2:0] src_i,
    input  logic             chg_any_i,
    input  logic             ack_we_i,
    input  logic [SRC_W-2:0] ack_data_i,
    input  logic             mask_we_i,
    input  logic [SRC_W-1:0] mask_data_i,
    output logic [SRC_W-1:0] status_o,
    output logic [SRC_W-1:0] mask_o,
    output logic             irq_o
);
    localparam int unsigned EXT_W = SRC_W - 1;

    logic [EXT_W-1:0] ext_q;
    logic [SRC_W-1:0] mask_q;

    // One sticky status bit per external source.
    for (genvar i = 0; i < EXT_W; i++) begin : g_src
        // Latch a high source; clear on a written 1 unless the source is high.
        always_ff @(posedge clk) begin
            if (!rst_n)
                ext_q[i] <= 1'b0;
            else if (src_i[i])
                ext_q[i] <= 1'b1;
            else if (ack_we_i && ack_data_i[i])
                ext_q[i] <= 1'b0;
        end
    end

    // Hold the mask written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= '0;
        else if (mask_we_i)
            mask_q <= mask_data_i;
    end

    assign status_o = {chg_any_i, ext_q};
    assign mask_o   = mask_q;
    assign irq_o    = |(status_o & mask_q);
endmodule

// File: rtl/irq_pio_ctrl.sv
// Top: bus decode, registered read mux, and the input, output and interrupt
// sub-blocks. Assumes single-cycle read/write strobes qualified by bus_sel.
module irq_pio_ctrl
    import irq_pio_pkg::*;
#(
    parameter int unsigned DW    = 8,
    parameter int unsigned IN_W  = 7,
    parameter int unsigned CHG_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [IN_W-1:0]   in_pins,
    input  logic [DW-2:0]     irq_src,
    output logic [DW-1:0]     out_pins,
    output logic              irq_pull
);
    localparam int unsigned PAD_W = DW - IN_W;
    localparam int unsigned LVL_W = DW - CHG_W;

    logic             wr_en, rd_en;
    logic [IN_W-1:0]  level;
    logic [CHG_W-1:0] chg;
    logic [DW-1:0]    status, mask, oreg, rd_mux;

    assign wr_en = bus_sel && bus_wr;
    assign rd_en = bus_sel && bus_rd;

    pio_in_filter #(.IN_W(IN_W), .CHG_W(CHG_W)) u_in (
        .clk       (clk),
        .rst_n     (rst_n),
        .pins_i    (in_pins),
        .chg_clr_i (rd_en && bus_addr == RA_CHG),
        .level_o   (level),
        .chg_o     (chg)
    );

    pio_out_reg #(.DW(DW)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (wr_en && bus_addr == RA_OSET),
        .clr_i  (wr_en && bus_addr == RA_OCLR),
        .data_i (bus_wdata),
        .q_o    (oreg)
    );

    irq_collect #(.SRC_W(DW)) u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (irq_src),
        .chg_any_i   (|chg),
        .ack_we_i    (wr_en && bus_addr == RA_STAT),
        .ack_data_i  (bus_wdata[DW-2:0]),
        .mask_we_i   (wr_en && bus_addr == RA_MASK),
        .mask_data_i (bus_wdata),
        .status_o    (status),
        .mask_o      (mask),
        .irq_o       (irq_pull)
    );

    // Select the addressed register for a read; unmapped codes read zero.
    always_comb begin
        unique case (bus_addr)
            RA_INLVL:  rd_mux = {{PAD_W{1'b0}}, level};
            RA_CHG:    rd_mux = {chg, level[LVL_W-1:0]};
            RA_STAT:   rd_mux = status;
            RA_MASK:   rd_mux = mask;
            RA_OUTREG: rd_mux = oreg;
            default:   rd_mux = '0;
        endcase
    end

    // Register the read data on a read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (rd_en)
            bus_rdata <= rd_mux;
    end

    assign out_pins = ~oreg;
endmodule

// File: rtl/irq_pio_ctrl_chk.sv
// Port-level checker for irq_pio_ctrl, bound into every instance.
module irq_pio_ctrl_chk #(
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_sel,
    input logic          bus_wr,
    input logic [3:0]    bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic [DW-1:0] out_pins,
    input logic          irq_pull
);
    logic set_cmd, clr_cmd, mask_clr;
    assign set_cmd  = bus_sel && bus_wr && bus_addr == 4'd5;
    assign clr_cmd  = bus_sel && bus_wr && bus_addr == 4'd6;
    assign mask_clr = bus_sel && bus_wr && bus_addr == 4'd3 && bus_wdata == '0;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (out_pins == '1 && !irq_pull));

    // R3
    set_drives_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_cmd |=> (out_pins & $past(bus_wdata)) == '0);

    // R3
    set_keeps_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_cmd |=> (out_pins | $past(bus_wdata)) == ($past(out_pins) | $past(bus_wdata)));

    // R4
    clr_drives_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cmd |=> (out_pins & $past(bus_wdata)) == $past(bus_wdata));

    // R2
    pins_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_cmd || clr_cmd) |=> $stable(out_pins));

    // R7
    mask_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_clr |=> !irq_pull);
endmodule

bind irq_pio_ctrl irq_pio_ctrl_chk #(.DW(DW)) chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .out_pins  (out_pins),
    .irq_pull  (irq_pull)
);

// File: tb/irq_pio_ctrl_test.sv
// Scoreboard bench: read tasks queue expected data, a monitor compares it.
module irq_pio_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [6:0] in_pins = '0;
    logic [6:0] irq_src = '0;
    logic [7:0] out_pins;
    logic       irq_pull;

    int checks = 0;
    int fails  = 0;
    logic rd_seen = 1'b0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    irq_pio_ctrl uut (.*);

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(req);
        @(negedge clk);
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic pulse_src(input logic [6:0] s);
        @(negedge clk);
        irq_src = s;
        @(negedge clk);
        irq_src = '0;
    endtask

    // Note a read strobe taken at the edge.
    always @(posedge clk) rd_seen <= bus_sel && bus_rd;

    // Compare registered read data with the queued expectation.
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0)
            check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end

    initial begin
        #4_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 pins at reset", out_pins, 8'hFF);
        check("R1 irq at reset", {7'd0, irq_pull}, 8'h00);
        rst_n = 1'b1;
        bus_read(4'd2, 8'h00, "R1 status");
        bus_read(4'd3, 8'h00, "R1 mask");
        bus_read(4'd4, 8'h00, "R1 outreg");

        // Output port set/clear
        bus_write(4'd5, 8'h05);
        check("R3 set 05", out_pins, 8'hFA);
        bus_write(4'd5, 8'h80);
        check("R3 set keeps others", out_pins, 8'h7A);
        bus_write(4'd6, 8'h01);
        check("R4 clear 01", out_pins, 8'h7B);
        bus_write(4'd6, 8'h00);
        check("R4 clear none", out_pins, 8'h7B);
        bus_read(4'd4, 8'h84, "R2 outreg readback");

        // Interrupt sources and mask
        pulse_src(7'h04);
        check("R7 masked off", {7'd0, irq_pull}, 8'h00);
        bus_read(4'd2, 8'h04, "R5 latched source");
        bus_write(4'd3, 8'h04);
        check("R7 unmasked asserts", {7'd0, irq_pull}, 8'h01);
        bus_read(4'd3, 8'h04, "R7 mask readback");
        bus_write(4'd2, 8'h04);
        check("R5 write-one clears", {7'd0, irq_pull}, 8'h00);
        pulse_src(7'h20);
        check("R7 other bit masked", {7'd0, irq_pull}, 8'h00);
        bus_read(4'd2, 8'h20, "R5 bit5 latched");
        @(negedge clk);
        irq_src = 7'h20;
        bus_write(4'd2, 8'h20);
        irq_src = '0;
        bus_read(4'd2, 8'h20, "R5 set wins over clear");
        bus_write(4'd2, 8'hFF);
        bus_read(4'd2, 8'h00, "R5 all cleared");

        // Input filter and change detection
        @(negedge clk);
        in_pins = 7'h02;
        repeat (6) @(negedge clk);
        bus_read(4'd0, 8'h02, "R8 level accepted");
        bus_read(4'd2, 8'h80, "R6 change pending");
        bus_read(4'd1, 8'h22, "R9 flags and levels");
        bus_read(4'd1, 8'h02, "R9 flags cleared by read");
        bus_read(4'd2, 8'h00, "R6 none pending");

        bus_write(4'd3, 8'h80);
        @(negedge clk);
        in_pins = 7'h0A;
        repeat (6) @(negedge clk);
        check("R7 change interrupt", {7'd0, irq_pull}, 8'h01);
        bus_read(4'd1, 8'h8A, "R9 bit3 flag");
        check("R9 read releases irq", {7'd0, irq_pull}, 8'h00);

        @(negedge clk);
        in_pins = 7'h0B;
        @(negedge clk);
        in_pins = 7'h0A;
        repeat (6) @(negedge clk);
        bus_read(4'd1, 8'h0A, "R8 glitch ignored");

        @(negedge clk);
        in_pins = 7'h2A;
        repeat (6) @(negedge clk);
        bus_read(4'd0, 8'h2A, "R8 upper input level");
        bus_read(4'd1, 8'h0A, "R9 upper input no flag");
        bus_read(4'd9, 8'h00, "R10 unmapped reads zero");

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule